// File: doc/BRIEF.md
# I2C Dual-Address Bus Slave

This block is an I2C target that sits on open-drain clock and data lines. It never drives a line high. It only pulls a line low through its output-enable pins, and the pad wires those enables to an open-drain driver. Both incoming lines first pass through a synchronizer and a majority-vote filter. The filtered lines feed a condition detector, which spots START and STOP, and a byte engine. The byte engine shifts serial bits in, most significant bit first, and compares the first byte against a programmable address. With the address-width select low, it compares a 7-bit address. With the select high, it runs a two-byte 10-bit match. The general call address is accepted in both modes.

A host reads received bytes from a buffer register and writes bytes to be sent into a transmit holding register. A one-cycle pulse marks each completed receive byte. A separate pulse marks each address match. START and STOP each give an interrupt pulse and a status flag, so the host can tell whether the bus is busy or free. When a read address arrives and no byte is waiting, the block holds the clock low until the host supplies one. When the enable input is low, the block drives neither line and ignores the bus.

Top module: `i2c_dual_slave`

## Requirements
- R1: After reset, and on every cycle that follows a cycle with `en` low, `scl_oe`, `sda_oe`, `start_flag`, `stop_flag` and `tx_mode` are all 0. While `en` is low, traffic to the own address gets no acknowledge (the data line stays high on the ninth clock) and no `addr_match` pulse.
- R2: START is a falling data line while the clock is high. On START, `start_irq` pulses once, `start_flag` becomes 1 and `stop_flag` becomes 0. STOP is a rising data line while the clock is high. On STOP, `stop_irq` pulses once, `stop_flag` becomes 1 and `start_flag` becomes 0. The two flags are never both 1.
- R3: When `mode10`=0, a first byte whose upper seven bits equal `own_addr[6:0]` is acknowledged by pulling the data line low on the ninth clock, and `addr_match` pulses once. Bit 0 of that byte is the direction: 0 selects receive and 1 selects transmit.
- R4: In either mode, the first byte 0x00 (general call) is acknowledged, pulses `addr_match`, sets `gen_call` to 1 until the next START, and selects receive.
- R5: When `mode10`=1, a first byte equal to 11110, then `own_addr[9:8]`, then a 0 bit, is acknowledged without an `addr_match` pulse. A second byte equal to `own_addr[7:0]` is then acknowledged, pulses `addr_match` and selects receive. A different second byte gets no acknowledge.
- R6: When `mode10`=1, a first byte of 11110, `own_addr[9:8]`, 1 is acknowledged and selects transmit only if a full 10-bit match has occurred since the last STOP. Otherwise it gets no acknowledge.
- R7: In receive, each data byte is assembled most significant bit first. If `rx_full` is 0, the byte is copied to `rx_data`, `rx_full` becomes 1, `byte_ready` pulses once and the byte is acknowledged. A `rx_rd` pulse clears `rx_full` and `overflow`.
- R8: A data byte that completes while `rx_full` is 1 sets `overflow` to 1 and gets no acknowledge, and `rx_data` keeps the earlier byte.
- R9: In transmit, the byte written through `tx_data`/`tx_wr` is sent most significant bit first. The data line changes only while the clock is low. The data line is released on the ninth clock. A master NACK (high on the ninth clock) returns the block to idle, with `tx_mode`=0.
- R10: When transmit begins, or continues after a master ACK, and no byte is waiting, the block holds the clock low (`scl_oe`=1) until `tx_wr` arrives. It then drives the first bit and releases the clock.
- R11: A pulse on either line that lasts one system clock is ignored. It adds no clock edge and no START or STOP.
- R12: After a first byte that matches neither the own address nor the general call, the block sends no acknowledge and ignores the bus until the next START. In that time `rx_full` and `addr_match` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low releases both lines and clears state |
| mode10 | input | 1 | 0: 7-bit address, 1: 10-bit address |
| own_addr | input | 10 | Own address; bits [6:0] are used in 7-bit mode, all bits in 10-bit mode |
| scl_i | input | 1 | Clock line as seen at the pad |
| sda_i | input | 1 | Data line as seen at the pad |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| tx_data | input | 8 | Byte to transmit |
| tx_wr | input | 1 | One-cycle strobe that loads `tx_data` |
| rx_rd | input | 1 | One-cycle strobe: host has read `rx_data` |
| rx_data | output | 8 | Last received data byte |
| rx_full | output | 1 | `rx_data` holds an unread byte |
| byte_ready | output | 1 | One-cycle pulse per stored receive byte |
| addr_match | output | 1 | One-cycle pulse per completed address match |
| gen_call | output | 1 | Current transfer was addressed by general call |
| overflow | output | 1 | A byte arrived while `rx_full` was set |
| tx_mode | output | 1 | Block is transmitting |
| start_irq | output | 1 | One-cycle pulse on START |
| stop_irq | output | 1 | One-cycle pulse on STOP |
| start_flag | output | 1 | Last bus condition was START |
| stop_flag | output | 1 | Last bus condition was STOP |

## Verification
The bench looks for the cases where the address logic can go subtly wrong. It sends a 10-bit header alone, to catch an engine that reports the match one byte early. It follows the header with a wrong low byte, which an engine that skips the second compare would acknowledge. It sends a read header after a STOP, which an engine that keeps the 10-bit match across transfers would accept. It also sends a second byte before the host has read the first. A broken buffer would either overwrite the byte or acknowledge it. It starts a read with nothing to send, which a missing clock hold would turn into garbage on the bus. It adds one-clock spikes on both lines, which an unfiltered design would count as extra bits or as false START and STOP conditions. Random 7-bit transfers with matching and non-matching addresses confirm the acknowledge decision and MSB-first data order against an address model in the bench.

// File: rtl/i2c_dsl_pkg.sv
package i2c_dsl_pkg;
   localparam int BYTE_W  = 8;
   localparam int ADDR_W  = 10;
   localparam int BIT_CW  = 4;
   localparam logic [4:0] TEN_HDR = 5'b11110;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR2,
      ST_RECV,
      ST_SEND
   } eng_st_t;
endpackage

// File: rtl/i2c_dsl_filter.sv
module i2c_dsl_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int VOTE_TAPS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int HALF = VOTE_TAPS / 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (VOTE_TAPS < 1 || (VOTE_TAPS % 2) == 0) begin : g_bad_vote
         $error("VOTE_TAPS must be odd and positive");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end

   generate
      if (VOTE_TAPS == 1) begin : g_novote
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout <= 1'b1;
            else        dout <= sync_q[SYNC_STAGES-1];
         end
      end else begin : g_vote
         logic [VOTE_TAPS-1:0] win_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_q <= '1;
               dout  <= 1'b1;
            end else begin
               win_q <= {win_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
               dout  <= ($countones(win_q) > HALF);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/i2c_dsl_cond.sv
module i2c_dsl_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic start_irq,
   output logic stop_irq,
   output logic start_flag,
   output logic stop_flag
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise  = en &  scl & ~scl_q;
   assign scl_fall  = en & ~scl &  scl_q;
   assign start_det = en & scl & scl_q &  sda_q & ~sda;
   assign stop_det  = en & scl & scl_q & ~sda_q &  sda;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_irq  <= 1'b0;
         stop_irq   <= 1'b0;
         start_flag <= 1'b0;
         stop_flag  <= 1'b0;
      end else if (!en) begin
         start_irq  <= 1'b0;
         stop_irq   <= 1'b0;
         start_flag <= 1'b0;
         stop_flag  <= 1'b0;
      end else begin
         start_irq <= start_det;
         stop_irq  <= stop_det;
         if (start_det) begin
            start_flag <= 1'b1;
            stop_flag  <= 1'b0;
         end else if (stop_det) begin
            start_flag <= 1'b0;
            stop_flag  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/i2c_dsl_engine.sv
module i2c_dsl_engine
   import i2c_dsl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              mode10,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              sda,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              tx_wr,
   input  logic              rx_rd,
   output logic              sda_oe,
   output logic              scl_oe,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_full,
   output logic              byte_ready,
   output logic              addr_match,
   output logic              gen_call,
   output logic              overflow,
   output logic              tx_mode
);
   localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W);
   localparam logic [BIT_CW-1:0] ACK_BIT  = BIT_CW'(BYTE_W + 1);

   eng_st_t           st, nxt_st;
   logic [BIT_CW-1:0] cnt;
   logic [BYTE_W-1:0] sr, tsr, tx_buf;
   logic              tx_valid, ten_ok, mnack, stretch;

   logic is_gc, own7, hdr_hit, lo_hit;
   assign is_gc   = (sr == '0);
   assign own7    = (sr[7:1] == own_addr[6:0]);
   assign hdr_hit = (sr[7:3] == TEN_HDR) && (sr[2:1] == own_addr[9:8]);
   assign lo_hit  = (sr == own_addr[7:0]);
   assign tx_mode = (st == ST_SEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || !en) begin
         st         <= ST_IDLE;
         nxt_st     <= ST_IDLE;
         cnt        <= '0;
         sr         <= '0;
         tsr        <= '0;
         tx_buf     <= '0;
         tx_valid   <= 1'b0;
         ten_ok     <= 1'b0;
         mnack      <= 1'b0;
         stretch    <= 1'b0;
         sda_oe     <= 1'b0;
         scl_oe     <= 1'b0;
         rx_data    <= '0;
         rx_full    <= 1'b0;
         byte_ready <= 1'b0;
         addr_match <= 1'b0;
         gen_call   <= 1'b0;
         overflow   <= 1'b0;
      end else begin
         byte_ready <= 1'b0;
         addr_match <= 1'b0;
         if (tx_wr) begin
            tx_buf   <= tx_data;
            tx_valid <= 1'b1;
         end
         if (rx_rd) begin
            rx_full  <= 1'b0;
            overflow <= 1'b0;
         end
         if (stop_det) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            ten_ok  <= 1'b0;
            sda_oe  <= 1'b0;
            scl_oe  <= 1'b0;
            stretch <= 1'b0;
         end else if (start_det) begin
            st       <= ST_ADDR;
            cnt      <= '0;
            sda_oe   <= 1'b0;
            scl_oe   <= 1'b0;
            stretch  <= 1'b0;
            gen_call <= 1'b0;
         end else if (stretch) begin
            if (tx_valid) begin
               tsr      <= tx_buf;
               tx_valid <= 1'b0;
               sda_oe   <= ~tx_buf[BYTE_W-1];
               scl_oe   <= 1'b0;
               stretch  <= 1'b0;
            end
         end else if (st != ST_IDLE) begin
            if (scl_rise) begin
               if (cnt != LAST_BIT) sr <= {sr[BYTE_W-2:0], sda};
               else                 mnack <= sda;
               cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
               if (cnt == LAST_BIT) begin
                  nxt_st <= ST_IDLE;
                  unique case (st)
                     ST_ADDR: begin
                        if (is_gc) begin
                           sda_oe     <= 1'b1;
                           addr_match <= 1'b1;
                           gen_call   <= 1'b1;
                           nxt_st     <= ST_RECV;
                        end else if (!mode10 && own7) begin
                           sda_oe     <= 1'b1;
                           addr_match <= 1'b1;
                           nxt_st     <= sr[0] ? ST_SEND : ST_RECV;
                        end else if (mode10 && hdr_hit && !sr[0]) begin
                           sda_oe <= 1'b1;
                           ten_ok <= 1'b0;
                           nxt_st <= ST_ADDR2;
                        end else if (mode10 && hdr_hit && sr[0] && ten_ok) begin
                           sda_oe     <= 1'b1;
                           addr_match <= 1'b1;
                           nxt_st     <= ST_SEND;
                        end
                     end
                     ST_ADDR2: begin
                        if (lo_hit) begin
                           sda_oe     <= 1'b1;
                           addr_match <= 1'b1;
                           ten_ok     <= 1'b1;
                           nxt_st     <= ST_RECV;
                        end
                     end
                     ST_RECV: begin
                        nxt_st <= ST_RECV;
                        if (rx_full) begin
                           overflow <= 1'b1;
                        end else begin
                           rx_data    <= sr;
                           rx_full    <= 1'b1;
                           byte_ready <= 1'b1;
                           sda_oe     <= 1'b1;
                        end
                     end
                     ST_SEND: begin
                        sda_oe <= 1'b0;
                        nxt_st <= ST_SEND;
                     end
                     default: nxt_st <= ST_IDLE;
                  endcase
               end else if (cnt == ACK_BIT) begin
                  cnt    <= '0;
                  sda_oe <= 1'b0;
                  if (st == ST_SEND && mnack) begin
                     st <= ST_IDLE;
                  end else begin
                     st <= nxt_st;
                     if (nxt_st == ST_SEND) begin
                        if (tx_valid) begin
                           tsr      <= tx_buf;
                           tx_valid <= 1'b0;
                           sda_oe   <= ~tx_buf[BYTE_W-1];
                        end else begin
                           stretch <= 1'b1;
                           scl_oe  <= 1'b1;
                        end
                     end
                  end
               end else if (st == ST_SEND && cnt != '0) begin
                  tsr    <= {tsr[BYTE_W-2:0], 1'b0};
                  sda_oe <= ~tsr[BYTE_W-2];
               end
            end
         end
      end
   end
endmodule

// File: rtl/i2c_dual_slave.sv
module i2c_dual_slave #(
   parameter int SYNC_STAGES = 2,
   parameter int VOTE_TAPS   = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       mode10,
   input  logic [9:0] own_addr,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       scl_oe,
   output logic       sda_oe,
   input  logic [7:0] tx_data,
   input  logic       tx_wr,
   input  logic       rx_rd,
   output logic [7:0] rx_data,
   output logic       rx_full,
   output logic       byte_ready,
   output logic       addr_match,
   output logic       gen_call,
   output logic       overflow,
   output logic       tx_mode,
   output logic       start_irq,
   output logic       stop_irq,
   output logic       start_flag,
   output logic       stop_flag
);
   logic scl_f, sda_f;
   logic scl_rise, scl_fall, start_det, stop_det;

   i2c_dsl_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_fscl (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f)
   );
   i2c_dsl_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_fsda (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f)
   );

   i2c_dsl_cond u_cond (
      .clk(clk), .rst_n(rst_n), .en(en), .scl(scl_f), .sda(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .start_irq(start_irq), .stop_irq(stop_irq),
      .start_flag(start_flag), .stop_flag(stop_flag)
   );

   i2c_dsl_engine u_eng (
      .clk(clk), .rst_n(rst_n), .en(en), .mode10(mode10), .own_addr(own_addr),
      .sda(sda_f), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .tx_data(tx_data), .tx_wr(tx_wr), .rx_rd(rx_rd),
      .sda_oe(sda_oe), .scl_oe(scl_oe), .rx_data(rx_data), .rx_full(rx_full),
      .byte_ready(byte_ready), .addr_match(addr_match), .gen_call(gen_call),
      .overflow(overflow), .tx_mode(tx_mode)
   );
endmodule

// File: rtl/i2c_dual_slave_chk.sv
module i2c_dual_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic scl_i,
   input logic scl_oe,
   input logic sda_oe,
   input logic rx_full,
   input logic byte_ready,
   input logic addr_match,
   input logic overflow,
   input logic tx_mode,
   input logic start_irq,
   input logic stop_irq,
   input logic start_flag,
   input logic stop_flag
);
   AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!sda_oe && !scl_oe && !start_flag && !stop_flag && !tx_mode)); // R1
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_flag && stop_flag)); // R2
   AST_START_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      start_irq |-> (start_flag && !stop_flag)); // R2
   AST_STOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      stop_irq |-> (stop_flag && !start_flag)); // R2
   AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      addr_match |=> !addr_match); // R3
   AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ready |-> rx_full); // R7
   AST_OVF_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> (!sda_oe && !byte_ready)); // R8
   AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !$stable(sda_oe)) |-> !scl_i); // R9
   AST_HOLD_SEND: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe |-> tx_mode); // R10
endmodule

bind i2c_dual_slave i2c_dual_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .scl_i(scl_i), .scl_oe(scl_oe),
   .sda_oe(sda_oe), .rx_full(rx_full), .byte_ready(byte_ready),
   .addr_match(addr_match), .overflow(overflow), .tx_mode(tx_mode),
   .start_irq(start_irq), .stop_irq(stop_irq),
   .start_flag(start_flag), .stop_flag(stop_flag)
);

// File: tb/i2c_dual_slave_test.sv
module i2c_dual_slave_test;
   localparam int CLK_PERIOD = 10;
   localparam int PH = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic mode10 = 1'b0;
   logic [9:0] own_addr = 10'h03A;
   logic mscl = 1'b1, msda = 1'b1;
   logic [7:0] tx_data = 8'h00;
   logic tx_wr = 1'b0, rx_rd = 1'b0;
   logic scl_oe, sda_oe, rx_full, byte_ready, addr_match, gen_call, overflow;
   logic tx_mode, start_irq, stop_irq, start_flag, stop_flag;
   logic [7:0] rx_data;
   logic scl_bus, sda_bus;

   assign scl_bus = mscl & ~scl_oe;
   assign sda_bus = msda & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_dual_slave uut (
      .clk(clk), .rst_n(rst_n), .en(en), .mode10(mode10), .own_addr(own_addr),
      .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .tx_data(tx_data), .tx_wr(tx_wr), .rx_rd(rx_rd), .rx_data(rx_data),
      .rx_full(rx_full), .byte_ready(byte_ready), .addr_match(addr_match),
      .gen_call(gen_call), .overflow(overflow), .tx_mode(tx_mode),
      .start_irq(start_irq), .stop_irq(stop_irq),
      .start_flag(start_flag), .stop_flag(stop_flag)
   );

   int n_ready = 0, n_match = 0, n_start = 0, n_stop = 0;
   always @(posedge clk) begin
      if (byte_ready) n_ready <= n_ready + 1;
      if (addr_match) n_match <= n_match + 1;
      if (start_irq)  n_start <= n_start + 1;
      if (stop_irq)   n_stop  <= n_stop + 1;
   end

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      @(negedge clk); msda = 1'b1; wt(PH);
      mscl = 1'b1; wt(PH);
      msda = 1'b0; wt(PH);
      mscl = 1'b0; wt(PH);
   endtask

   task automatic bus_stop();
      @(negedge clk); msda = 1'b0; wt(PH);
      mscl = 1'b1; wt(PH);
      msda = 1'b1; wt(PH);
   endtask

   // glitch: 0 none, 1 one-clock spike on clock while low, 2 one-clock spike on data while clock high
   task automatic write_bit(input bit b, input int glitch);
      @(negedge clk); msda = b; wt(PH);
      if (glitch == 1) begin mscl = 1'b1; wt(1); mscl = 1'b0; wt(PH); end
      mscl = 1'b1;
      while (!scl_bus) @(negedge clk);
      wt(PH/2);
      if (glitch == 2) begin msda = ~b; wt(1); msda = b; end
      wt(PH/2);
      mscl = 1'b0; wt(PH);
   endtask

   task automatic read_bit(output bit b);
      @(negedge clk); msda = 1'b1; wt(PH);
      mscl = 1'b1;
      while (!scl_bus) @(negedge clk);
      wt(PH);
      b = sda_bus;
      mscl = 1'b0; wt(PH);
   endtask

   task automatic send_byte(input logic [7:0] v, input int glitch, output bit ack);
      bit x;
      for (int i = 7; i >= 0; i--) write_bit(v[i], (i == 5) ? glitch : 0);
      read_bit(x);
      ack = ~x;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] v);
      bit x;
      for (int i = 7; i >= 0; i--) begin read_bit(x); v[i] = x; end
      write_bit(~mack, 0);
   endtask

   task automatic host_read();
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
      wt(2);
   endtask

   task automatic host_write(input logic [7:0] v);
      @(negedge clk); tx_data = v; tx_wr = 1'b1;
      @(negedge clk); tx_wr = 1'b0;
   endtask

   function automatic bit exp_ack7(input logic [7:0] first, input logic [6:0] own);
      return (first == 8'h00) || (first[7:1] == own);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      bit ack;
      logic [7:0] v;
      int m0, r0, s0, p0;
      void'($urandom(32'd4242));
      wt(5);
      rst_n = 1'b1;
      wt(3);
      chk("R1 reset sda_oe", sda_oe, 0);
      chk("R1 reset scl_oe", scl_oe, 0);
      chk("R1 reset flags", {start_flag, stop_flag}, 0);
      chk("R1 reset tx_mode", tx_mode, 0);

      // disabled: no acknowledge, no match
      m0 = n_match;
      bus_start();
      chk("R1 disabled start_flag", start_flag, 0);
      send_byte(8'h74, 0, ack);
      chk("R1 disabled nack", ack, 0);
      chk("R1 disabled match", n_match - m0, 0);
      bus_stop();

      en = 1'b1; wt(4);

      // START/STOP flags
      s0 = n_start; p0 = n_stop;
      bus_start();
      chk("R2 start irq", n_start - s0, 1);
      chk("R2 start flags", {start_flag, stop_flag}, 2);
      // 7-bit own address write with filter glitch on the clock line
      m0 = n_match; r0 = n_ready;
      send_byte(8'h74, 0, ack);
      chk("R3 own ack", ack, 1);
      chk("R3 match pulse", n_match - m0, 1);
      send_byte(8'hB6, 1, ack);
      chk("R11 clock spike ack", ack, 1);
      chk("R11 clock spike data", rx_data, 8'hB6);
      chk("R7 byte_ready", n_ready - r0, 1);
      chk("R7 rx_full", rx_full, 1);
      host_read();
      chk("R7 rx_rd clears", rx_full, 0);
      s0 = n_start; p0 = n_stop;
      send_byte(8'h5C, 2, ack);
      chk("R11 data spike no cond", (n_start - s0) + (n_stop - p0), 0);
      chk("R11 data spike data", rx_data, 8'h5C);
      host_read();
      bus_stop();
      chk("R2 stop irq", n_stop - p0, 1);
      chk("R2 stop flags", {start_flag, stop_flag}, 1);

      // overflow
      bus_start();
      send_byte(8'h74, 0, ack);
      send_byte(8'h11, 0, ack);
      chk("R7 first ack", ack, 1);
      send_byte(8'h22, 0, ack);
      chk("R8 overflow nack", ack, 0);
      chk("R8 overflow flag", overflow, 1);
      chk("R8 data kept", rx_data, 8'h11);
      bus_stop();
      host_read();
      chk("R7 overflow cleared", overflow, 0);

      // non-matching address ignored
      m0 = n_match; r0 = n_ready;
      bus_start();
      send_byte(8'h56, 0, ack);
      chk("R12 mismatch nack", ack, 0);
      send_byte(8'h00, 0, ack);
      chk("R12 ignored until start", ack, 0);
      chk("R12 no store", n_ready - r0, 0);
      chk("R12 no match", n_match - m0, 0);
      bus_stop();

      // general call
      bus_start();
      send_byte(8'h00, 0, ack);
      chk("R4 gc ack", ack, 1);
      chk("R4 gc flag", gen_call, 1);
      send_byte(8'h3D, 0, ack);
      chk("R4 gc data", rx_data, 8'h3D);
      host_read();
      bus_stop();

      // 7-bit read, preloaded
      host_write(8'hC3);
      bus_start();
      send_byte(8'h75, 0, ack);
      chk("R3 read ack", ack, 1);
      chk("R3 tx_mode", tx_mode, 1);
      recv_byte(1'b0, v);
      chk("R9 tx data", v, 8'hC3);
      chk("R9 nack idle", tx_mode, 0);
      bus_stop();

      // clock hold with empty transmit buffer
      bus_start();
      send_byte(8'h75, 0, ack);
      wt(40);
      chk("R10 scl held", scl_oe, 1);
      chk("R10 bus low", scl_bus, 0);
      host_write(8'h69);
      wt(10);
      chk("R10 scl released", scl_oe, 0);
      recv_byte(1'b1, v);
      chk("R9 byte after hold", v, 8'h69);
      wt(40);
      chk("R10 hold after ack", scl_oe, 1);
      host_write(8'h0F);
      recv_byte(1'b0, v);
      chk("R9 second byte", v, 8'h0F);
      chk("R9 idle after nack", tx_mode, 0);
      bus_stop();

      // random 7-bit writes
      for (int k = 0; k < 8; k++) begin
         logic [6:0] a;
         logic [7:0] d, first;
         bit ex;
         a = ($urandom % 2 == 0) ? own_addr[6:0] : 7'($urandom);
         d = 8'($urandom);
         first = {a, 1'b0};
         ex = exp_ack7(first, own_addr[6:0]);
         bus_start();
         send_byte(first, 0, ack);
         chk("R3 random address ack", ack, ex);
         if (ex) begin
            send_byte(d, 0, ack);
            chk("R7 random data ack", ack, 1);
            chk("R7 random data", rx_data, d);
            host_read();
         end
         bus_stop();
      end

      // 10-bit mode, own address 0x2C5
      mode10 = 1'b1; own_addr = 10'h2C5; wt(4);
      m0 = n_match;
      bus_start();
      send_byte(8'h74, 0, ack);
      chk("R5 7-bit byte in 10-bit mode", ack, 0);
      bus_stop();
      bus_start();
      send_byte(8'hF4, 0, ack);
      chk("R5 header ack", ack, 1);
      chk("R5 no early match", n_match - m0, 0);
      send_byte(8'hC4, 0, ack);
      chk("R5 wrong low nack", ack, 0);
      bus_stop();
      bus_start();
      send_byte(8'hF5, 0, ack);
      chk("R6 read without match", ack, 0);
      bus_stop();
      bus_start();
      send_byte(8'hF4, 0, ack);
      send_byte(8'hC5, 0, ack);
      chk("R5 low ack", ack, 1);
      chk("R5 match pulse", n_match - m0, 1);
      send_byte(8'h3C, 0, ack);
      chk("R5 data", rx_data, 8'h3C);
      host_read();
      host_write(8'h96);
      bus_start();
      send_byte(8'hF5, 0, ack);
      chk("R6 repeated start read ack", ack, 1);
      recv_byte(1'b0, v);
      chk("R6 read data", v, 8'h96);
      bus_stop();
      bus_start();
      send_byte(8'hF5, 0, ack);
      chk("R6 match cleared by stop", ack, 0);
      bus_stop();

      // disable drops everything
      en = 1'b0; wt(3);
      chk("R1 disable flags", {start_flag, stop_flag}, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule